// File: doc/BRIEF.md
# Challenge-Response SHA-1 MAC Engine

This block produces a 160-bit message authentication code by running a single SHA-1 compression over a 512-bit message that it assembles itself. The message holds a 64-bit secret, a 64-bit challenge held in an internal register, a 64-bit middle field, and ten fixed padding words. Depending on the mode, the middle field is a device identifier, a parameter-defined filler or all ones. The secret enters only the hash datapath. Only the resulting code is visible at the outputs.

A host first loads a challenge, then pulses `start_i` with a mode. The engine spends one clock per round over 80 rounds, adds the initial chaining values and pulses `done_o`. The digest is then available in parallel, and also bit-serially, one bit per read request, starting at the least significant bit of word A. Every accepted run clears the challenge, so each run needs a fresh challenge. In the two next-secret modes, words D and E of the digest are offered on a separate output with a one-cycle valid pulse, for an external store to capture.

Top module: `sha_mac_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o`, `next_valid_o` and `bit_o` are 0, and `digest_o` and `next_secret_o` are all zeros.
- R2: The message words are as follows, with W0 the first word hashed:
  - W0 = secret[63:32] and W1 = secret[31:0].
  - W2 and W3 are the challenge register, upper half first.
  - W4 and W5 are the middle field, upper half first.
  - W6 to W15 are `PAD_WORDS`, W6 in its top 32 bits. The default is W6 = 80000000h, W7 to W14 = 0 and W15 = 00000180h.
  
  `digest_o` = {A,B,C,D,E}, with A in bits 159:128, and is the standard SHA-1 compression of this block from the standard initial values, including the final addition. `digest_o` holds its value until the next run completes.
- R3: `mode_i` selects the middle field.
  - 0: plain code; the middle field is `NOID_FILL`, default all zeros.
  - 1: code with identifier; the middle field is `dev_id_i`.
  - 2: next secret, without identifier; the middle field is all ones.
  - 3: next secret, with identifier; the middle field is `dev_id_i`.
  
  `mode_i`, `secret_i` and `dev_id_i` are sampled on the edge that accepts start.
- R4: Timing of a run:
  - The first rising edge with `start_i` high and `busy_o` low accepts the run.
  - `busy_o` is high from that edge until the 81st edge after it.
  - `done_o` is high for exactly one cycle, starting at that 81st edge.
- R5: `start_i` is ignored while `busy_o` is high. The running computation and its result are not affected.
- R6: Every accepted start clears the challenge register to zero. A second run without a new write therefore hashes a zero challenge.
- R7: When `chal_we_i` is high on an edge, `chal_i` is written into the challenge register. The exception is an edge that also accepts a start: there the clear wins and the write is lost, and the run that starts uses the previous challenge.
- R8: At the edge where `done_o` rises, the serial register is loaded so that `bit_o` shows A[0].
  - Each edge with `rd_i` high while `busy_o` is low moves `bit_o` to the next bit.
  - The order is A bit 0 to 31, then B, C, D and E in the same way, for 160 bits in total.
- R9: In modes 2 and 3, `next_secret_o` becomes {D,E}, with D in bits 63:32, and `next_valid_o` pulses together with `done_o`. In modes 0 and 1, `next_valid_o` stays 0 and `next_secret_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request; taken only when idle |
| mode_i | input | 2 | Run mode (see R3) |
| secret_i | input | 64 | Secret, sampled at start |
| chal_we_i | input | 1 | Challenge write strobe |
| chal_i | input | 64 | Challenge write data |
| dev_id_i | input | 64 | Device identifier, sampled at start |
| rd_i | input | 1 | Serial read request, one bit per cycle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| digest_o | output | 160 | Last computed code {A,B,C,D,E} |
| bit_o | output | 1 | Current serial digest bit |
| next_secret_o | output | 64 | Derived secret {D,E} |
| next_valid_o | output | 1 | One-cycle pulse marking a new derived secret |

## Verification
The embedded properties take the host's inputs as unconstrained, with two exceptions. They assume that `start_i` pulses arriving during a run carry arbitrary modes, which is exactly what R5 says must not disturb the captured mode. They also assume that `rd_i` is asserted only after the serial register has been loaded. The stimulus follows both assumptions:
- Random runs draw mode, secret, identifier and challenge from `$urandom` with a fixed seed.
- Directed cases cover the following:
  - a start pulse injected in the middle of a run, with a different mode and secret;
  - a challenge write on the same edge as the accepting start;
  - a run issued with no challenge written.
- Serial reads begin only after `done_o`.

// File: rtl/sha_mac_pkg.sv
// Shared types, constants and helper functions for the SHA-1 code engine.
// Assumes 32-bit words and the fixed 80-round SHA-1 schedule.
package sha_mac_pkg;

    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 16;
    localparam int ROUNDS    = 80;
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int BLK_W     = WORD_W * MSG_WORDS;
    localparam int DIG_W     = WORD_W * 5;
    localparam int HALF_W    = 2 * WORD_W;

    localparam logic [WORD_W-1:0] IV_A = 32'h6745_2301;
    localparam logic [WORD_W-1:0] IV_B = 32'hEFCD_AB89;
    localparam logic [WORD_W-1:0] IV_C = 32'h98BA_DCFE;
    localparam logic [WORD_W-1:0] IV_D = 32'h1032_5476;
    localparam logic [WORD_W-1:0] IV_E = 32'hC3D2_E1F0;

    typedef enum logic [1:0] {
        MODE_MAC    = 2'd0,
        MODE_MAC_ID = 2'd1,
        MODE_NXT    = 2'd2,
        MODE_NXT_ID = 2'd3
    } mac_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] e;
    } sha_state_t;

    // Round-group boolean function.
    function automatic logic [WORD_W-1:0] grp_func(input logic [1:0] grp,
                                                   input logic [WORD_W-1:0] b,
                                                   input logic [WORD_W-1:0] c,
                                                   input logic [WORD_W-1:0] d);
        case (grp)
            2'd0:    grp_func = (b & c) | (~b & d);
            2'd2:    grp_func = (b & c) | (b & d) | (c & d);
            default: grp_func = b ^ c ^ d;
        endcase
    endfunction

    // Round-group additive constant.
    function automatic logic [WORD_W-1:0] grp_const(input logic [1:0] grp);
        case (grp)
            2'd0:    grp_const = 32'h5A82_7999;
            2'd1:    grp_const = 32'h6ED9_EBA1;
            2'd2:    grp_const = 32'h8F1B_BCDC;
            default: grp_const = 32'hCA62_C1D6;
        endcase
    endfunction

endpackage

// File: rtl/sha_msg_sched.sv
// Message schedule: a 16-word circular shift register.
// The head word is W_t of the current round.
// load_i fills it from a 512-bit block, with W0 in the top bits.
// adv_i drops the head and appends the next expanded word.
// Assumes load_i and adv_i are never high together.
module sha_msg_sched
    import sha_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [BLK_W-1:0]  block_i,
    output logic [WORD_W-1:0] w_o
);

    logic [WORD_W-1:0] w_q [MSG_WORDS];
    logic [WORD_W-1:0] mix;
    logic [WORD_W-1:0] w_new;

    // Next expanded word from taps 13, 8, 2 and 0, rotated left by one.
    always_comb begin
        mix   = w_q[13] ^ w_q[8] ^ w_q[2] ^ w_q[0];
        w_new = {mix[WORD_W-2:0], mix[WORD_W-1]};
    end

    assign w_o = w_q[0];

    for (genvar i = 0; i < MSG_WORDS; i++) begin : g_word
        // Per-slot register: block load, shift toward the head, or hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q[i] <= '0;
            end else if (load_i) begin
                w_q[i] <= block_i[BLK_W-1-i*WORD_W -: WORD_W];
            end else if (adv_i) begin
                if (i == MSG_WORDS - 1) begin
                    w_q[i] <= w_new;
                end else begin
                    w_q[i] <= w_q[i+1];
                end
            end
        end
    end

    // R2: the schedule is never reloaded and advanced in the same cycle.
    assert_sched_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && adv_i));

endmodule

// File: rtl/sha_round_core.sv
// Working variables A to E with one SHA-1 round per step.
// init_i loads the initial values. step_i runs round rnd_i using w_i.
// final_i latches the digest, which is the state plus the initial values.
// sum_o is that same sum, available combinationally.
// Assumes that at most one command is high in any cycle.
module sha_round_core
    import sha_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              step_i,
    input  logic              final_i,
    input  logic [RND_W-1:0]  rnd_i,
    input  logic [WORD_W-1:0] w_i,
    output logic [DIG_W-1:0]  sum_o,
    output logic [DIG_W-1:0]  digest_o
);

    sha_state_t        st_q;
    sha_state_t        st_nx;
    logic [1:0]        grp;
    logic [WORD_W-1:0] tmp;
    logic [DIG_W-1:0]  dig_q;

    // Round group from the round index.
    always_comb begin
        if (rnd_i < RND_W'(20))      grp = 2'd0;
        else if (rnd_i < RND_W'(40)) grp = 2'd1;
        else if (rnd_i < RND_W'(60)) grp = 2'd2;
        else                         grp = 2'd3;
    end

    // One compression round.
    always_comb begin
        tmp = {st_q.a[WORD_W-6:0], st_q.a[WORD_W-1:WORD_W-5]}
            + grp_func(grp, st_q.b, st_q.c, st_q.d)
            + w_i + grp_const(grp) + st_q.e;
        st_nx.a = tmp;
        st_nx.b = st_q.a;
        st_nx.c = {st_q.b[1:0], st_q.b[WORD_W-1:2]};
        st_nx.d = st_q.c;
        st_nx.e = st_q.d;
    end

    // Final addition of the initial chaining values.
    assign sum_o = {st_q.a + IV_A, st_q.b + IV_B, st_q.c + IV_C,
                    st_q.d + IV_D, st_q.e + IV_E};

    // Working-variable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (init_i) begin
            st_q <= '{a: IV_A, b: IV_B, c: IV_C, d: IV_D, e: IV_E};
        end else if (step_i) begin
            st_q <= st_nx;
        end
    end

    // Digest register, written only by the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q <= '0;
        end else if (final_i) begin
            dig_q <= sum_o;
        end
    end

    assign digest_o = dig_q;

    // R4: commands from the sequencer are mutually exclusive.
    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_i, step_i, final_i}));

    // R4: a round is never run with an index past the last round.
    assert_rnd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rnd_i < RND_W'(ROUNDS)));

    // R2: the digest changes only through a final step.
    assert_dig_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !final_i |=> $stable(dig_q));

endmodule

// File: rtl/sha_serial_out.sv
// Bit-serial digest port.
// load_i captures a digest so that bit 0 of word A appears first.
// Each rd_i moves the port on by one bit, through A, B, C, D and E, each from its LSB.
// Assumes rd_i is gated off by the caller while a run is in progress.
module sha_serial_out
    import sha_mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             rd_i,
    input  logic [DIG_W-1:0] digest_i,
    output logic             bit_o
);

    logic [DIG_W-1:0] sr_q;
    logic [DIG_W-1:0] reord;

    // Reverse the word order so that word A sits at the low end.
    for (genvar k = 0; k < 5; k++) begin : g_reord
        assign reord[k*WORD_W +: WORD_W] = digest_i[DIG_W-1-k*WORD_W -: WORD_W];
    end

    // Shift register: load on completion, shift right on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= reord;
        end else if (rd_i) begin
            sr_q <= {1'b0, sr_q[DIG_W-1:1]};
        end
    end

    assign bit_o = sr_q[0];

    // R8: after a read, the port shows the bit that was next in line.
    assert_ser_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load_i) |=> (bit_o == $past(sr_q[1])));

endmodule

// File: rtl/sha_mac_engine.sv
// Top of the challenge-response SHA-1 code engine.
// It holds the self-clearing challenge and builds the 512-bit message.
// It sequences 80 rounds and the final addition, then publishes:
//   - the digest;
//   - the serial stream;
//   - in next-secret modes, the derived secret.
// Assumes secret_i and dev_id_i are valid on the edge that accepts start.
module sha_mac_engine
    import sha_mac_pkg::*;
#(
    parameter logic [10*32-1:0] PAD_WORDS = {32'h8000_0000, {8{32'h0000_0000}}, 32'h0000_0180},
    parameter logic [63:0]      NOID_FILL = 64'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   mode_i,
    input  logic [63:0]  secret_i,
    input  logic         chal_we_i,
    input  logic [63:0]  chal_i,
    input  logic [63:0]  dev_id_i,
    input  logic         rd_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [159:0] digest_o,
    output logic         bit_o,
    output logic [63:0]  next_secret_o,
    output logic         next_valid_o
);

    eng_state_e        st_q;
    logic [RND_W-1:0]  rnd_q;
    mac_mode_e         mode_q;
    logic [HALF_W-1:0] chal_q;
    logic [HALF_W-1:0] mid;
    logic [BLK_W-1:0]  blk;
    logic [WORD_W-1:0] w_cur;
    logic [DIG_W-1:0]  sum;
    logic              accept;
    logic              in_run;
    logic              in_fin;
    logic              done_q;
    logic              nv_q;
    logic [HALF_W-1:0] ns_q;

    assign accept = start_i && (st_q == ST_IDLE);
    assign in_run = (st_q == ST_RUN);
    assign in_fin = (st_q == ST_FIN);

    // Middle field selection and message assembly.
    always_comb begin
        case (mac_mode_e'(mode_i))
            MODE_MAC: mid = NOID_FILL;
            MODE_NXT: mid = '1;
            default:  mid = dev_id_i;
        endcase
        blk = {secret_i, chal_q, mid, PAD_WORDS};
    end

    // Sequencer: idle, then 80 rounds, then the final addition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rnd_q  <= '0;
            mode_q <= MODE_MAC;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    st_q   <= ST_RUN;
                    rnd_q  <= '0;
                    mode_q <= mac_mode_e'(mode_i);
                end
                ST_RUN: begin
                    rnd_q <= rnd_q + 1'b1;
                    if (rnd_q == RND_W'(ROUNDS - 1)) st_q <= ST_FIN;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Challenge register: cleared by an accepted start, otherwise written on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chal_q <= '0;
        end else if (accept) begin
            chal_q <= '0;
        end else if (chal_we_i) begin
            chal_q <= chal_i;
        end
    end

    // Completion pulse and derived-secret publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            nv_q   <= 1'b0;
            ns_q   <= '0;
        end else begin
            done_q <= in_fin;
            nv_q   <= in_fin && mode_q[1];
            if (in_fin && mode_q[1]) ns_q <= sum[HALF_W-1:0];
        end
    end

    sha_msg_sched u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .adv_i   (in_run),
        .block_i (blk),
        .w_o     (w_cur)
    );

    sha_round_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (accept),
        .step_i   (in_run),
        .final_i  (in_fin),
        .rnd_i    (rnd_q),
        .w_i      (w_cur),
        .sum_o    (sum),
        .digest_o (digest_o)
    );

    sha_serial_out u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (in_fin),
        .rd_i     (rd_i && !busy_o),
        .digest_i (sum),
        .bit_o    (bit_o)
    );

    assign busy_o        = (st_q != ST_IDLE);
    assign done_o        = done_q;
    assign next_valid_o  = nv_q;
    assign next_secret_o = ns_q;

    // R4: the completion pulse lasts a single cycle.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: an accepted start leaves the challenge register at zero.
    assert_chal_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (chal_q == '0));

    // R5: a start request during a run does not change the captured mode.
    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mode_q));

    // R9: the derived secret is only ever flagged along with completion.
    assert_nv_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid_o |-> done_o);

    // R4: busy falls exactly when done rises.
    assert_busy_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($fell(busy_o)));

endmodule

// File: tb/sha_mac_engine_tb.sv
module sha_mac_engine_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [1:0]   mode_i;
    logic [63:0]  secret_i;
    logic         chal_we_i;
    logic [63:0]  chal_i;
    logic [63:0]  dev_id_i;
    logic         rd_i;
    logic         busy_o;
    logic         done_o;
    logic [159:0] digest_o;
    logic         bit_o;
    logic [63:0]  next_secret_o;
    logic         next_valid_o;

    localparam logic [319:0] PADV = {32'h8000_0000, {8{32'h0000_0000}}, 32'h0000_0180};
    localparam logic [63:0]  NOID = 64'h0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [63:0]  mdl_chal = '0;
    logic [63:0]  mdl_ns   = '0;
    logic [159:0] mdl_dig  = '0;

    sha_mac_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .secret_i(secret_i), .chal_we_i(chal_we_i), .chal_i(chal_i),
        .dev_id_i(dev_id_i), .rd_i(rd_i), .busy_o(busy_o), .done_o(done_o),
        .digest_o(digest_o), .bit_o(bit_o), .next_secret_o(next_secret_o),
        .next_valid_o(next_valid_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Independent SHA-1 compression of one block with the standard IV.
    function automatic logic [159:0] ref_sha(input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE;
        d = 32'h10325476; e = 32'hC3D2E1F0;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + w[i] + k + e;
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
                d + 32'h10325476, e + 32'hC3D2E1F0};
    endfunction

    // R3: middle field per mode.
    function automatic logic [511:0] mk_blk(input logic [1:0] m, input logic [63:0] s,
                                            input logic [63:0] ch, input logic [63:0] id);
        logic [63:0] md;
        case (m)
            2'd0:    md = NOID;
            2'd2:    md = '1;
            default: md = id;
        endcase
        return {s, ch, md, PADV};
    endfunction

    task automatic wr_chal(input logic [63:0] v);
        @(negedge clk);
        chal_we_i = 1'b1; chal_i = v;
        @(posedge clk);
        @(negedge clk);
        chal_we_i = 1'b0;
        mdl_chal = v;
    endtask

    // Runs one computation and checks timing, digest and derived secret.
    // collide: a challenge write on the accepting edge. poke: a start pulse mid-run.
    task automatic run(input logic [1:0] m, input logic [63:0] s, input logic [63:0] id,
                       input bit collide, input logic [63:0] cv, input bit poke, input string tag);
        logic [159:0] exp;
        exp = ref_sha(mk_blk(m, s, mdl_chal, id));
        @(negedge clk);
        start_i = 1'b1; mode_i = m; secret_i = s; dev_id_i = id;
        if (collide) begin chal_we_i = 1'b1; chal_i = cv; end
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; chal_we_i = 1'b0;
        secret_i = ~s; dev_id_i = ~id; mode_i = ~m;
        mdl_chal = '0;
        chk(busy_o == 1'b1, {"R4 busy after accept ", tag}, busy_o, 1);
        for (int i = 1; i < 80; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && i == 40) begin
                start_i = 1'b1; secret_i = 64'h0123_4567_89AB_CDEF;
            end else begin
                start_i = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0 && busy_o == 1'b1, {"R4 not done at edge 80 ", tag},
            {done_o, busy_o}, 2'b01);
        chk(digest_o == mdl_dig, {"R2 digest held during run ", tag}, digest_o, mdl_dig);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b1 && busy_o == 1'b0, {"R4 done at edge 81 ", tag},
            {done_o, busy_o}, 2'b10);
        chk(digest_o == exp, {(poke ? "R5 " : "R2 R3 "), "digest ", tag}, digest_o, exp);
        if (m[1]) begin
            mdl_ns = exp[63:0];
            chk(next_valid_o == 1'b1, {"R9 next_valid pulse ", tag}, next_valid_o, 1);
        end else begin
            chk(next_valid_o == 1'b0, {"R9 no next_valid in code mode ", tag}, next_valid_o, 0);
        end
        chk(next_secret_o == mdl_ns, {"R9 next_secret ", tag}, next_secret_o, mdl_ns);
        mdl_dig = exp;
    endtask

    task automatic post_done(input string tag);
        @(negedge clk);
        chk(done_o == 1'b0 && next_valid_o == 1'b0, {"R4 done single cycle ", tag},
            {done_o, next_valid_o}, 0);
    endtask

    task automatic read_stream(input string tag);
        logic [159:0] got;
        logic [159:0] exp;
        exp = {mdl_dig[31:0], mdl_dig[63:32], mdl_dig[95:64], mdl_dig[127:96], mdl_dig[159:128]};
        for (int k = 0; k < 160; k++) begin
            got[k] = bit_o;
            rd_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        rd_i = 1'b0;
        chk(got == exp, {"R8 serial order ", tag}, got, exp);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] s, id, cv;
        logic [1:0]  m;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; secret_i = '0;
        chal_we_i = 1'b0; chal_i = '0; dev_id_i = '0; rd_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, next_valid_o, bit_o} == 4'b0, "R1 reset flags",
            {busy_o, done_o, next_valid_o, bit_o}, 0);
        chk(digest_o == '0 && next_secret_o == '0, "R1 reset data",
            digest_o ^ {96'h0, next_secret_o}, 0);

        // Directed: plain code with zeros, then with ID.
        run(2'd0, 64'h0, 64'h0, 0, 0, 0, "zero");
        post_done("zero");
        wr_chal(64'hDEAD_BEEF_0BAD_F00D);
        run(2'd1, 64'h1122_3344_5566_7788, 64'h3400_00A5_5A5A_01C3, 0, 0, 0, "id");
        read_stream("id");
        // R6: second run without a new challenge hashes zero.
        run(2'd1, 64'h1122_3344_5566_7788, 64'h3400_00A5_5A5A_01C3, 0, 0, 0, "rerun");
        // R9: next-secret modes.
        wr_chal(64'hCAFE_F00D_1234_5678);
        run(2'd2, 64'hFFFF_0000_FFFF_0000, 64'h0, 0, 0, 0, "nxt");
        post_done("nxt");
        wr_chal(64'h0F0F_0F0F_F0F0_F0F0);
        run(2'd3, 64'hA5A5_A5A5_5A5A_5A5A, 64'h7777_8888_9999_AAAA, 0, 0, 0, "nxtid");
        run(2'd0, 64'h1, 64'h2, 0, 0, 0, "ns-keep");
        // R7: a write on the accepting edge is lost.
        wr_chal(64'h1111_2222_3333_4444);
        run(2'd0, 64'h5555, 64'h0, 1, 64'h9999_AAAA_BBBB_CCCC, 0, "collide");
        run(2'd0, 64'h5555, 64'h0, 0, 0, 0, "after-collide");
        // R5: start during a run is ignored.
        wr_chal(64'h2468_ACE0_1357_9BDF);
        run(2'd2, 64'hBEEF, 64'h0, 0, 0, 1, "poke");
        read_stream("poke");

        // Random runs.
        for (int r = 0; r < 12; r++) begin
            s  = {$urandom, $urandom};
            id = {$urandom, $urandom};
            cv = {$urandom, $urandom};
            m  = 2'($urandom % 4);
            if (r % 3 != 2) wr_chal(cv);
            run(m, s, id, 0, 0, (r % 4 == 1), "rand");
            if (r % 2 == 0) read_stream("rand");
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule